// File: doc/BRIEF.md
# Sum-on-Sign Trellis Step Engine

This block advances a 32-state Viterbi trellis by one stage for every received symbol. A symbol is a pair of signed 16-bit soft values. For each of the 16 butterflies the engine takes a pair of sign codes from a fixed table and adds or subtracts the two soft values to form a single branch metric. It then runs a dual add-compare-select step that yields two new path metrics and two survivor-decision bits.

Path metrics are kept in two register banks. One bank is read as the source while the other is written as the destination, and the two swap roles after each symbol. A start pulse loads the initial metrics and opens a block of a given number of symbols. Symbols arrive over a valid/ready stream. For each symbol the engine emits one 32-bit decision word, and it raises a done flag together with the last word of the block.

Top module: `trellis_step_engine`

## Requirements
- R1: For butterfly k the branch metric is b = sh·hi + sl·lo, taken modulo 2^16. Here hi is sym_data[31:16] and lo is sym_data[15:0], both signed. The sign sh is −1 when bit k of NEG_HI is 1 and +1 otherwise, and sl follows NEG_LO in the same way. The defaults are NEG_HI = 0x55AA and NEG_LO = 0x9696.
- R2: With old metrics P (from the source bank), butterfly k writes two new metrics. New state 2k gets max(P[k]+b, P[k+16]−b). New state 2k+1 gets max(P[k]−b, P[k+16]+b). All sums are 16-bit two's complement with wraparound, and the comparison is signed.
- R3: Bit 2k of the decision word is 1 exactly when the candidate from state k+16 is strictly greater for new state 2k. Bit 2k+1 is defined the same way for new state 2k+1. On a tie the candidate from state k wins and the bit is 0.
- R4: The metrics written while processing one symbol are the source metrics for the next symbol of the same block.
- R5: A start pulse in idle sets every state metric to 0xC000, except state 1, which is set to 0. A block run after a restart therefore produces the same words as a fresh block fed the same symbols.
- R6: sym_ready is high only while the engine waits for the next symbol of a block. After it accepts a symbol, the engine spends 16 cycles, one butterfly per cycle. dec_valid is a one-cycle pulse in the 17th cycle after the accepting cycle, and sym_ready is high again in that same cycle.
- R7: A start pulse clears done. done rises together with the dec_valid of the final symbol and stays high until the next start. If num_syms is 0, done is high in the cycle after start and no word is emitted.
- R8: A start pulse is ignored while a block is in progress.
- R9: After reset, sym_ready, dec_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block (honoured only in idle) |
| num_syms | input | CNT_W | Number of symbols in the block |
| sym_valid | input | 1 | Symbol present |
| sym_ready | output | 1 | Engine can take a symbol |
| sym_data | input | 32 | {hi soft value, lo soft value} |
| dec_valid | output | 1 | Decision word valid (one cycle) |
| dec_word | output | NSTATE | Survivor decisions, bit n for new state n |
| done | output | 1 | Block finished |

## Verification
Two events can fall in the same cycle: the emission of one symbol's decision word and the acceptance of the next symbol. The bench provokes this by holding sym_valid high throughout a block, so that each new symbol is taken in the cycle its predecessor's word appears. Every word is compared with an arithmetic trellis model, and its cycle is compared with the accepting cycle plus 17. A second block inserts gaps in the stream so the two events fall apart, and the same checks must still hold.

// File: rtl/trellis_pkg.sv
package trellis_pkg;

    localparam int SOFT_W = 16;

    typedef logic signed [SOFT_W-1:0] metric_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_WAIT = 2'd1,
        ENG_RUN  = 2'd2
    } eng_state_t;

    typedef struct packed {
        metric_t pm_even;
        metric_t pm_odd;
        logic    pick_even;
        logic    pick_odd;
    } acs_res_t;

    // apply a +1 / -1 code to a soft value
    function automatic metric_t apply_sign(metric_t v, logic neg);
        return neg ? metric_t'(-v) : v;
    endfunction

endpackage

// File: rtl/trellis_bm.sv
module trellis_bm
    import trellis_pkg::*;
#(
    parameter int NBFLY = 16,
    parameter logic [NBFLY-1:0] NEG_HI = 'h55AA,
    parameter logic [NBFLY-1:0] NEG_LO = 'h9696,
    localparam int IDXW = $clog2(NBFLY)
) (
    input  logic [IDXW-1:0] bfly,
    input  metric_t         sym_hi,
    input  metric_t         sym_lo,
    output metric_t         bm
);
    logic neg_h, neg_l;

    assign neg_h = NEG_HI[bfly];
    assign neg_l = NEG_LO[bfly];
    assign bm    = apply_sign(sym_hi, neg_h) + apply_sign(sym_lo, neg_l);

endmodule

// File: rtl/trellis_acs.sv
module trellis_acs
    import trellis_pkg::*;
(
    input  metric_t  pm_low,   // state k
    input  metric_t  pm_high,  // state k + NSTATE/2
    input  metric_t  bm,
    output acs_res_t res
);
    metric_t even_a, even_b, odd_a, odd_b;

    always_comb begin
        even_a = pm_low + bm;
        even_b = pm_high - bm;
        odd_a  = pm_low - bm;
        odd_b  = pm_high + bm;
        res.pick_even = (even_b > even_a);
        res.pick_odd  = (odd_b > odd_a);
        res.pm_even   = res.pick_even ? even_b : even_a;
        res.pm_odd    = res.pick_odd  ? odd_b  : odd_a;
    end

endmodule

// File: rtl/trellis_pm_banks.sv
module trellis_pm_banks
    import trellis_pkg::*;
#(
    parameter int      NSTATE     = 32,
    parameter metric_t INIT_PM    = 16'shC000,
    parameter int      ZERO_STATE = 1,
    localparam int     NBFLY      = NSTATE / 2,
    localparam int     IDXW       = $clog2(NBFLY)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_init,
    input  logic            sel,
    input  logic [IDXW-1:0] idx,
    output metric_t         rd_low,
    output metric_t         rd_high,
    input  logic            wr_en,
    input  metric_t         wr_even,
    input  metric_t         wr_odd
);
    metric_t mem [2][NSTATE];

    always_ff @(posedge clk) begin
        if (rst || load_init) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < NSTATE; s++) begin
                    mem[b][s] <= (s == ZERO_STATE) ? '0 : INIT_PM;
                end
            end
        end else if (wr_en) begin
            mem[~sel][{idx, 1'b0}] <= wr_even;
            mem[~sel][{idx, 1'b1}] <= wr_odd;
        end
    end

    assign rd_low  = mem[sel][{1'b0, idx}];
    assign rd_high = mem[sel][{1'b1, idx}];

endmodule

// File: rtl/trellis_step_engine.sv
module trellis_step_engine
    import trellis_pkg::*;
#(
    parameter int      NSTATE     = 32,
    parameter int      CNT_W      = 8,
    parameter logic [NSTATE/2-1:0] NEG_HI = 'h55AA,
    parameter logic [NSTATE/2-1:0] NEG_LO = 'h9696,
    parameter metric_t INIT_PM    = 16'shC000,
    parameter int      ZERO_STATE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  num_syms,
    input  logic              sym_valid,
    output logic              sym_ready,
    input  logic [2*SOFT_W-1:0] sym_data,
    output logic              dec_valid,
    output logic [NSTATE-1:0] dec_word,
    output logic              done
);
    localparam int NBFLY = NSTATE / 2;
    localparam int IDXW  = $clog2(NBFLY);
    localparam logic [IDXW-1:0] LAST_BFLY = IDXW'(NBFLY - 1);

    eng_state_t        state;
    logic              bank_sel;
    logic [IDXW-1:0]   bfly;
    logic [CNT_W-1:0]  left;
    metric_t           sym_hi, sym_lo;
    logic [NSTATE-1:0] dec_acc, dec_next;
    metric_t           bm, pm_low, pm_high;
    acs_res_t          acs;
    logic              running, load_init;

    assign running   = (state == ENG_RUN);
    assign load_init = (state == ENG_IDLE) && start;
    assign sym_ready = (state == ENG_WAIT);

    trellis_bm #(.NBFLY(NBFLY), .NEG_HI(NEG_HI), .NEG_LO(NEG_LO)) u_bm (
        .bfly   (bfly),
        .sym_hi (sym_hi),
        .sym_lo (sym_lo),
        .bm     (bm)
    );

    trellis_pm_banks #(.NSTATE(NSTATE), .INIT_PM(INIT_PM), .ZERO_STATE(ZERO_STATE)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .load_init (load_init),
        .sel       (bank_sel),
        .idx       (bfly),
        .rd_low    (pm_low),
        .rd_high   (pm_high),
        .wr_en     (running),
        .wr_even   (acs.pm_even),
        .wr_odd    (acs.pm_odd)
    );

    trellis_acs u_acs (
        .pm_low  (pm_low),
        .pm_high (pm_high),
        .bm      (bm),
        .res     (acs)
    );

    always_comb begin
        dec_next = dec_acc;
        dec_next[{bfly, 1'b0}] = acs.pick_even;
        dec_next[{bfly, 1'b1}] = acs.pick_odd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            bank_sel  <= 1'b0;
            bfly      <= '0;
            left      <= '0;
            sym_hi    <= '0;
            sym_lo    <= '0;
            dec_acc   <= '0;
            dec_word  <= '0;
            dec_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        bank_sel <= 1'b0;
                        left     <= num_syms;
                        done     <= (num_syms == '0);
                        if (num_syms != '0) state <= ENG_WAIT;
                    end
                end
                ENG_WAIT: begin
                    if (sym_valid) begin
                        sym_hi <= metric_t'(sym_data[2*SOFT_W-1:SOFT_W]);
                        sym_lo <= metric_t'(sym_data[SOFT_W-1:0]);
                        bfly   <= '0;
                        state  <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    dec_acc <= dec_next;
                    bfly    <= bfly + 1'b1;
                    if (bfly == LAST_BFLY) begin
                        dec_word  <= dec_next;
                        dec_valid <= 1'b1;
                        bank_sel  <= ~bank_sel;
                        left      <= left - 1'b1;
                        if (left == CNT_W'(1)) begin
                            state <= ENG_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ENG_WAIT;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/trellis_step_engine_chk.sv
module trellis_step_engine_chk #(
    parameter int NSTATE = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CNT_W-1:0]  num_syms,
    input logic              sym_valid,
    input logic              sym_ready,
    input logic              dec_valid,
    input logic [NSTATE-1:0] dec_word,
    input logic              done
);
    logic [5:0] since_acc;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) since_acc <= 6'd63;
        else if (sym_valid && sym_ready) since_acc <= 6'd0;
        else if (since_acc != 6'd63) since_acc <= since_acc + 6'd1;
    end

    always_ff @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_QUIET: assert (!sym_ready && !dec_valid && !done); // R9
        end
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready) |=> !sym_ready); // R6

    AST_DECISION_LATENCY: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (since_acc == 6'd16)); // R6

    AST_DECISION_PULSE: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R7

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> !sym_ready); // R7

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (sym_ready && start && !sym_valid) |=> sym_ready); // R8

endmodule

bind trellis_step_engine trellis_step_engine_chk #(.NSTATE(NSTATE), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .num_syms  (num_syms),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .dec_valid (dec_valid),
    .dec_word  (dec_word),
    .done      (done)
);

// File: tb/trellis_step_engine_test.sv
`timescale 1ns/1ps
module trellis_step_engine_test;

    localparam logic [15:0] TB_NEG_HI = 16'h55AA;
    localparam logic [15:0] TB_NEG_LO = 16'h9696;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  num_syms = '0;
    logic        sym_valid = 1'b0;
    logic        sym_ready;
    logic [31:0] sym_data = '0;
    logic        dec_valid;
    logic [31:0] dec_word;
    logic        done;

    always #2 clk = ~clk;

    trellis_step_engine uut (
        .clk(clk), .rst(rst), .start(start), .num_syms(num_syms),
        .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
        .dec_valid(dec_valid), .dec_word(dec_word), .done(done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [31:0] got_w[$];
    int          got_c[$];
    int          acc_c[$];
    logic [31:0] exp_w[$];
    logic [31:0] syms[32];
    logic [31:0] blk_a[32];

    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            got_w.push_back(dec_word);
            got_c.push_back(cyc);
        end
    end

    // arithmetic trellis model (R1..R5)
    logic signed [15:0] mpm[32];

    task automatic model_init();
        for (int s = 0; s < 32; s++) mpm[s] = (s == 1) ? 16'sd0 : 16'shC000;
    endtask

    task automatic model_sym(input logic [31:0] d, output logic [31:0] w);
        logic signed [15:0] hi, lo, b, a0, a1, c0, c1;
        logic signed [15:0] nx[32];
        hi = d[31:16];
        lo = d[15:0];
        w = '0;
        for (int k = 0; k < 16; k++) begin
            b  = (TB_NEG_HI[k] ? -hi : hi) + (TB_NEG_LO[k] ? -lo : lo);
            a0 = mpm[k] + b;
            a1 = mpm[k+16] - b;
            c0 = mpm[k] - b;
            c1 = mpm[k+16] + b;
            w[2*k]   = (a1 > a0);
            w[2*k+1] = (c1 > c0);
            nx[2*k]   = (a1 > a0) ? a1 : a0;
            nx[2*k+1] = (c1 > c0) ? c1 : c0;
        end
        for (int s = 0; s < 32; s++) mpm[s] = nx[s];
    endtask

    task automatic run_block(input int n, input bit gaps, input bit poke_start);
        logic [31:0] w;
        int i, k;
        bit busy_checked;
        got_w.delete(); got_c.delete(); acc_c.delete(); exp_w.delete();
        model_init();
        for (int j = 0; j < n; j++) begin
            model_sym(syms[j], w);
            exp_w.push_back(w);
        end
        @(negedge clk);
        start = 1'b1;
        num_syms = 8'(n);
        @(negedge clk);
        start = 1'b0;
        num_syms = 8'd0;
        chk(done == 1'b0, "R7", "done cleared by start", done, 0);
        i = 0; k = 0; busy_checked = 0;
        while (i < n) begin
            @(negedge clk);
            k++;
            start = (poke_start && k == 20);
            if (i == 1 && !busy_checked && !dec_valid) begin
                busy_checked = 1;
                chk(sym_ready == 1'b0, "R6", "ready low while busy", sym_ready, 0);
            end
            if (gaps && (k % 4 == 1)) begin
                sym_valid = 1'b0;
            end else begin
                sym_valid = 1'b1;
                sym_data = syms[i];
                if (sym_ready) begin
                    acc_c.push_back(cyc);
                    i++;
                end
            end
        end
        @(negedge clk);
        sym_valid = 1'b0;
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk(got_w.size() == n, "R7", "word count", got_w.size(), n);
        chk(done == 1'b1, "R7", "done after block", done, 1);
        chk(sym_ready == 1'b0, "R6", "ready low after block", sym_ready, 0);
        for (int j = 0; j < n && j < got_w.size(); j++) begin
            chk(got_w[j] == exp_w[j], "R2 R3 R4", $sformatf("word %0d", j), got_w[j], exp_w[j]);
            chk(got_c[j] == acc_c[j] + 17, "R6", $sformatf("word %0d cycle", j), got_c[j], acc_c[j] + 17);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R6: actual hung expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        logic signed [15:0] h, l;
        repeat (3) @(negedge clk);
        chk(sym_ready == 0, "R9", "reset ready", sym_ready, 0);
        chk(dec_valid == 0, "R9", "reset dec_valid", dec_valid, 0);
        chk(done == 0, "R9", "reset done", done, 0);
        rst = 1'b0;

        // block A: small soft values, continuous stream (R1 R2 R3 R4 R6)
        seed = 7;
        for (int j = 0; j < 18; j++) begin
            seed = seed * 1103515245 + 12345;
            h = 16'(((seed >>> 8) & 15) - 8);
            seed = seed * 1103515245 + 12345;
            l = 16'(((seed >>> 8) & 15) - 8);
            syms[j] = {h, l};
            blk_a[j] = {h, l};
        end
        run_block(18, 1'b0, 1'b0);

        // block B: extreme values, wraparound, stream with gaps (R1 R2 R6)
        for (int j = 0; j < 8; j++) begin
            case (j % 4)
                0: syms[j] = {16'sh7FFF, 16'sh7FFF};
                1: syms[j] = {16'sh8000, 16'sh7FFF};
                2: syms[j] = {16'sh8000, 16'sh8000};
                default: syms[j] = {16'sh4001, 16'shC003};
            endcase
        end
        run_block(8, 1'b1, 1'b0);

        // block C: restart reloads initial metrics (R5), start poked mid-block (R8)
        for (int j = 0; j < 5; j++) syms[j] = blk_a[j];
        run_block(5, 1'b0, 1'b1);

        // block D: zero symbols (R7)
        @(negedge clk);
        got_w.delete();
        start = 1'b1;
        num_syms = 8'd0;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R7", "done with zero symbols", done, 1);
        chk(sym_ready == 1'b0, "R7", "no ready with zero symbols", sym_ready, 0);
        repeat (20) @(negedge clk);
        chk(got_w.size() == 0, "R7", "no words with zero symbols", got_w.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule